// File: doc/BRIEF.md
# Firmware Exception Entry Vector Unit

This unit computes where a processor resumes when it takes an exception or interrupt. It resolves the destination inside the privileged firmware region and records the state needed to return. For each event the core presents a cause code, an 8-bit call-firmware function code, its current program counter, its current privileged-mode flag and the firmware base address. It then pulses a take strobe for one cycle.

On the next clock edge the unit registers three results:

- the new program counter, which is the firmware base plus an offset chosen by the cause;
- the saved exception address, which is the old program counter with the old privileged flag folded into bit 0;
- the privileged-mode flag, which is forced to one.

A cause code outside the defined set does not enter firmware. It raises an error flag alongside the completion pulse instead.

Top module: `fw_entry_unit`

## Requirements
- R1: After reset, `newPc` is 0, `savedAddr` is 0, `privOut` is 1, and `entryValid` and `entryErr` are both 0.
- R2: For the fixed causes, the offset is the cause code times 0x80. The cause codes are 0 reset, 1 machine check, 2 interprocessor interrupt, 3 clock interrupt, 4 device interrupt, 5 memory-management fault, 6 unaligned access, 7 illegal opcode, 8 arithmetic trap and 9 FP-disabled, so the offsets run from 0x000 to 0x480.
- R3: For cause 10 (call firmware) with `funcCode` bit 7 clear, the offset is 0x1000 + funcCode*64.
- R4: For cause 10 with `funcCode` bit 7 set, the offset is 0x2000 + (funcCode-0x80)*64.
- R5: For a defined cause, `newPc` = `fwBase` + offset, taken modulo 2^64.
- R6: For a defined cause, `savedAddr` = `curPc` with bit 0 ORed with `curPriv`.
- R7: For a defined cause, `privOut` becomes 1 whatever the value of `curPriv`.
- R8: For causes 11 to 15, `entryErr` is 1, `newPc` takes `curPc`, `privOut` takes `curPriv`, and `savedAddr` keeps its previous value.
- R9: Results appear on the first clock edge after `takeExc` is sampled high. `entryValid` is high for exactly the one cycle after each strobe cycle, and `entryErr` is never high without `entryValid`.
- R10: In a cycle where `takeExc` is low, `newPc`, `savedAddr` and `privOut` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| takeExc | input | 1 | Take-exception strobe |
| cause | input | 4 | Exception cause code |
| funcCode | input | 8 | Call-firmware function code |
| curPc | input | 64 | Current program counter |
| curPriv | input | 1 | Current privileged-mode flag |
| fwBase | input | 64 | Firmware base address |
| newPc | output | 64 | Program counter after entry |
| savedAddr | output | 64 | Saved exception address, bit 0 = previous mode |
| privOut | output | 1 | Privileged-mode flag after entry |
| entryValid | output | 1 | One-cycle completion pulse |
| entryErr | output | 1 | Unknown-cause flag, valid with `entryValid` |

## Verification
Every result of this unit is due exactly one clock edge after the strobe cycle, and that includes the error flag. Inputs are driven on the falling edge, so the bench pulses the strobe for one cycle and reads all outputs on the following falling edge. The bench then reads one falling edge later to confirm that the completion pulse has dropped and that the registered state held. Under the fixed seed, random events are mixed with directed corners: both call-firmware tables at their extreme codes, base wraparound, and every unknown cause.

// File: rtl/fw_entry_pkg.sv
package fw_entry_pkg;
  localparam int CAUSE_W = 4;
  localparam int FUNC_W  = 8;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_RESET   = 4'd0,
    CAUSE_MCHK    = 4'd1,
    CAUSE_IPI     = 4'd2,
    CAUSE_CLOCK   = 4'd3,
    CAUSE_DEVICE  = 4'd4,
    CAUSE_MMFAULT = 4'd5,
    CAUSE_UNALIGN = 4'd6,
    CAUSE_ILLOP   = 4'd7,
    CAUSE_ARITH   = 4'd8,
    CAUSE_FPOFF   = 4'd9,
    CAUSE_CALLFW  = 4'd10
  } cause_e;

  // strobes from control to datapath
  typedef struct packed {
    logic ldVector;   // defined cause: load vector, save address, set mode
    logic useCallFw;  // offset comes from the call-firmware tables
    logic badCause;   // unknown cause: pass current PC and mode through
  } strobes_t;
endpackage

// File: rtl/fw_entry_ctrl.sv
module fw_entry_ctrl
  import fw_entry_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               takeExc,
  input  logic [CAUSE_W-1:0] cause,
  output strobes_t           strobes,
  output logic               entryValid,
  output logic               entryErr
);
  logic knownCause;

  always_comb begin
    knownCause        = (cause <= CAUSE_CALLFW);
    strobes.ldVector  = takeExc && knownCause;
    strobes.useCallFw = (cause == CAUSE_CALLFW);
    strobes.badCause  = takeExc && !knownCause;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      entryValid <= 1'b0;
      entryErr   <= 1'b0;
    end else begin
      entryValid <= takeExc;
      entryErr   <= strobes.badCause;
    end
  end
endmodule

// File: rtl/fw_entry_dp.sv
module fw_entry_dp
  import fw_entry_pkg::*;
#(
  parameter int XLEN         = 64,
  parameter int VEC_SHIFT    = 7,
  parameter int SLOT_SHIFT   = 6,
  parameter int PRIV_TABLE   = 'h1000,
  parameter int UNPRIV_TABLE = 'h2000
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobes_t           strobes,
  input  logic [CAUSE_W-1:0] cause,
  input  logic [FUNC_W-1:0]  funcCode,
  input  logic [XLEN-1:0]    curPc,
  input  logic               curPriv,
  input  logic [XLEN-1:0]    fwBase,
  output logic [XLEN-1:0]    newPc,
  output logic [XLEN-1:0]    savedAddr,
  output logic               privOut
);
  localparam int VEC_PAD  = XLEN - CAUSE_W - VEC_SHIFT;
  localparam int SLOT_PAD = XLEN - (FUNC_W - 1) - SLOT_SHIFT;

  logic [XLEN-1:0] fixedOff, slotOff, tableBase, callOff, offset;

  always_comb begin
    fixedOff  = {{VEC_PAD{1'b0}}, cause, {VEC_SHIFT{1'b0}}};
    slotOff   = {{SLOT_PAD{1'b0}}, funcCode[FUNC_W-2:0], {SLOT_SHIFT{1'b0}}};
    tableBase = funcCode[FUNC_W-1] ? XLEN'(UNPRIV_TABLE) : XLEN'(PRIV_TABLE);
    callOff   = tableBase + slotOff;
    offset    = strobes.useCallFw ? callOff : fixedOff;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      newPc     <= '0;
      savedAddr <= '0;
      privOut   <= 1'b1;
    end else if (strobes.ldVector) begin
      newPc     <= fwBase + offset;
      savedAddr <= {curPc[XLEN-1:1], curPc[0] | curPriv};
      privOut   <= 1'b1;
    end else if (strobes.badCause) begin
      newPc     <= curPc;
      privOut   <= curPriv;
    end
  end
endmodule

// File: rtl/fw_entry_unit.sv
module fw_entry_unit
  import fw_entry_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               takeExc,
  input  logic [CAUSE_W-1:0] cause,
  input  logic [FUNC_W-1:0]  funcCode,
  input  logic [XLEN-1:0]    curPc,
  input  logic               curPriv,
  input  logic [XLEN-1:0]    fwBase,
  output logic [XLEN-1:0]    newPc,
  output logic [XLEN-1:0]    savedAddr,
  output logic               privOut,
  output logic               entryValid,
  output logic               entryErr
);
  strobes_t strobes;

  fw_entry_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .takeExc(takeExc), .cause(cause),
    .strobes(strobes), .entryValid(entryValid), .entryErr(entryErr)
  );

  fw_entry_dp #(.XLEN(XLEN)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cause(cause),
    .funcCode(funcCode), .curPc(curPc), .curPriv(curPriv), .fwBase(fwBase),
    .newPc(newPc), .savedAddr(savedAddr), .privOut(privOut)
  );
endmodule

// File: rtl/fw_entry_chk.sv
module fw_entry_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rstN,
  input logic            takeExc,
  input logic [3:0]      cause,
  input logic [XLEN-1:0] curPc,
  input logic            curPriv,
  input logic [XLEN-1:0] newPc,
  input logic [XLEN-1:0] savedAddr,
  input logic            privOut,
  input logic            entryValid,
  input logic            entryErr
);
  AST_PULSE_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    takeExc |=> entryValid); // R9
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rstN)
    !takeExc |=> !entryValid); // R9
  AST_ERR_WITH_VALID: assert property (@(posedge clk) disable iff (!rstN)
    entryErr |-> entryValid); // R9
  AST_MODE_SET: assert property (@(posedge clk) disable iff (!rstN)
    (entryValid && !entryErr) |-> privOut); // R7
  AST_SAVE_MODE: assert property (@(posedge clk) disable iff (!rstN)
    (takeExc && cause <= 4'd10) |=> savedAddr == ($past(curPc) | XLEN'($past(curPriv)))); // R6
  AST_BAD_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (takeExc && cause > 4'd10) |=> (entryErr && newPc == $past(curPc) && privOut == $past(curPriv))); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !takeExc |=> ($stable(newPc) && $stable(savedAddr) && $stable(privOut))); // R10
endmodule

bind fw_entry_unit fw_entry_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rstN(rstN), .takeExc(takeExc), .cause(cause), .curPc(curPc),
  .curPriv(curPriv), .newPc(newPc), .savedAddr(savedAddr), .privOut(privOut),
  .entryValid(entryValid), .entryErr(entryErr)
);

// File: tb/tb_fw_entry_unit.sv
`timescale 1ns/1ps
module tb_fw_entry_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        takeExc = 1'b0;
  logic [3:0]  cause = '0;
  logic [7:0]  funcCode = '0;
  logic [63:0] curPc = '0;
  logic        curPriv = 1'b0;
  logic [63:0] fwBase = '0;
  logic [63:0] newPc, savedAddr;
  logic        privOut, entryValid, entryErr;

  int nChecks = 0;
  int nFails = 0;
  logic [63:0] expPc, expSave;
  logic        expPriv;

  always #4 clk = ~clk;

  fw_entry_unit dut (.*);

  task automatic check(string req, logic [63:0] got, logic [63:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [63:0] offsetOf(logic [3:0] c, logic [7:0] f);
    if (c == 4'd10)
      return f[7] ? 64'h2000 + 64'(f - 8'h80) * 64 : 64'h1000 + 64'(f) * 64;
    return 64'(c) * 64'h80;
  endfunction

  task automatic takeOne(logic [3:0] c, logic [7:0] f, logic [63:0] pc,
                         logic p, logic [63:0] base, string req);
    cause = c; funcCode = f; curPc = pc; curPriv = p; fwBase = base;
    takeExc = 1'b1;
    if (c <= 4'd10) begin
      expPc = base + offsetOf(c, f);
      expSave = pc | 64'(p);
      expPriv = 1'b1;
    end else begin
      expPc = pc;
      expPriv = p;
    end
    @(negedge clk);
    takeExc = 1'b0;
    check({req, "/R9 valid"}, 64'(entryValid), 64'd1);
    check({req, "/R8 err"}, 64'(entryErr), 64'(c > 4'd10));
    check({req, " newPc"}, newPc, expPc);
    check({req, "/R6 savedAddr"}, savedAddr, expSave);
    check({req, "/R7 privOut"}, 64'(privOut), 64'(expPriv));
    cause = 4'($urandom); curPc = {$urandom, $urandom}; fwBase = {$urandom, $urandom};
    @(negedge clk);
    check("R9 pulse drops", 64'(entryValid), 64'd0);
    check("R10 hold newPc", newPc, expPc);
    check("R10 hold savedAddr", savedAddr, expSave);
    check("R10 hold privOut", 64'(privOut), 64'(expPriv));
  endtask

  initial begin
    #1_600_000;
    nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check("R1 newPc", newPc, 64'd0);
    check("R1 savedAddr", savedAddr, 64'd0);
    check("R1 privOut", 64'(privOut), 64'd1);
    check("R1 valid", 64'(entryValid), 64'd0);
    check("R1 err", 64'(entryErr), 64'd0);
    expPc = 0; expSave = 0; expPriv = 1;
    for (int c = 0; c < 10; c++)
      takeOne(4'(c), 8'h55, 64'h1000_0000_0000_0040, c[0], 64'h8000_0000, "R2");
    takeOne(4'd10, 8'h00, 64'h40, 1'b0, 64'h10_0000, "R3 low");
    takeOne(4'd10, 8'h7F, 64'h44, 1'b1, 64'h10_0000, "R3 high");
    takeOne(4'd10, 8'h80, 64'h48, 1'b0, 64'h10_0000, "R4 low");
    takeOne(4'd10, 8'hFF, 64'h4C, 1'b1, 64'h10_0000, "R4 high");
    takeOne(4'd9, 8'h00, 64'hABC0, 1'b0, 64'hFFFF_FFFF_FFFF_FF00, "R5 wrap");
    takeOne(4'd3, 8'h00, 64'hFFFF_FFFF_FFFF_FFFE, 1'b1, 64'h0, "R6 lsb");
    takeOne(4'd3, 8'h00, 64'h0000_0000_0000_0201, 1'b0, 64'h0, "R6 lsb keep");
    for (int c = 11; c < 16; c++)
      takeOne(4'(c), 8'h12, 64'hDEAD_BEEF_0000_1234, c[0], 64'h4000, "R8");
    for (int i = 0; i < 300; i++)
      takeOne(4'($urandom), 8'($urandom), {$urandom, $urandom}, 1'($urandom),
              {$urandom, $urandom}, "R5 random");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule